// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Multiple-Match Detection

This block is a fully associative address translation buffer. Each of its entries maps one page, sized by a power of two from 4 KiB to 2 GiB, from a 32-bit effective address to a 36-bit real address. Software loads entries one at a time through an indexed write port. A lookup port takes an effective address and the current process ID. In the same cycle, with no register on the path, it returns a hit flag, the translated real address and the index of the matching entry.

All entries are compared in parallel, and each entry masks its compare to its own page size. An entry may be tagged with a translation ID. An entry then matches only for that process, unless its ID is zero, in which case it matches every process. When two or more entries match one lookup, software has made a programming error. If the enable input is set, the block reports this on a separate error output. In every case the result is resolved the same way: the lowest-numbered matching entry wins.

Top module: `tlb_vp_mmu`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns hit_o=0.
- R2: A write updates an entry at the next rising clock edge. A lookup in the same cycle as that write sees the entry's old contents.
- R3: An entry matches when it is valid and effective-address bits [31:12+k] equal its page number bits [31:12+k]. Here k is the size code (0..19) and the page is 2^(12+k) bytes.
- R4: On a hit, ra_o takes bits [35:12+k] from the entry's real page number and bits [11+k:0] from lk_ea_i.
- R5: An entry whose translation ID is nonzero matches only when lk_pid_i equals that ID. An entry whose ID is zero matches any process ID.
- R6: A lookup with no matching entry, or with lk_vld_i low, gives hit_o=0, ra_o=0 and idx_o=0.
- R7: When several entries match, hit_o=1, and idx_o and ra_o come from the lowest-numbered match.
- R8: multi_hit_o is 1 exactly when the lookup is valid, mh_en_i=1 and two or more entries match. With mh_en_i=0 it stays 0.
- R9: A write to an index of 20 or above changes no entry.
- R10: An entry written with wr_vld_i=0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 5 | Entry index to write |
| wr_vld_i | input | 1 | Valid bit for the written entry |
| wr_epn_i | input | 20 | Effective page number (EA bits 31:12) |
| wr_rpn_i | input | 24 | Real page number (RA bits 35:12) |
| wr_sz_i | input | 5 | Size code k, where the page is 2^(12+k) bytes |
| wr_tid_i | input | 8 | Translation ID, 0 = global |
| lk_vld_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Lookup effective address |
| lk_pid_i | input | 8 | Current process ID |
| mh_en_i | input | 1 | Multiple-match report enable |
| hit_o | output | 1 | Lookup hit |
| ra_o | output | 36 | Translated real address |
| idx_o | output | 5 | Index of the winning entry |
| multi_hit_o | output | 1 | Multiple-match error report |

## Verification
On every cycle the assertions check four things. A miss drives zero address and index. An error report implies a hit under the enable. An error report is backed by at least two raw entry matches. The reported index is a real match with no lower-numbered match below it. Only the bench scenarios can show that the addresses are correct: the size-dependent masking, the concatenation of page number and offset, the translation-ID filtering, write timing against a same-cycle lookup, and whether out-of-range or invalid writes are ignored.

// File: rtl/tlb_vp_pkg.sv
package tlb_vp_pkg;
  localparam int EA_W   = 32;
  localparam int RA_W   = 36;
  localparam int PG_MIN = 12;
  localparam int SZ_W   = 5;
  localparam int TID_W  = 8;
  localparam int EPN_W  = EA_W - PG_MIN;
  localparam int RPN_W  = RA_W - PG_MIN;
  localparam int MAX_SZ = EA_W - 1 - PG_MIN;

  typedef struct packed {
    logic             vld;
    logic [EPN_W-1:0] epn;
    logic [RPN_W-1:0] rpn;
    logic [SZ_W-1:0]  sz;
    logic [TID_W-1:0] tid;
  } tlb_ent_t;

  // ones on the in-page offset bits; codes past the top size clamp to it
  function automatic logic [EA_W-1:0] off_mask(input logic [SZ_W-1:0] sz);
    int s;
    s = (int'(sz) > MAX_SZ) ? MAX_SZ : int'(sz);
    off_mask = (EA_W'(1) << (PG_MIN + s)) - EA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_vp_pkg::*;
(
  input  tlb_ent_t          ent_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic [TID_W-1:0]  pid_i,
  output logic              match_o,
  output logic [RA_W-1:0]   ra_o
);
  logic [EA_W-1:0] om;
  logic            tid_ok;
  logic            page_ok;

  always_comb begin
    om      = off_mask(ent_i.sz);
    tid_ok  = (ent_i.tid == '0) || (ent_i.tid == pid_i);
    page_ok = ((ea_i ^ {ent_i.epn, PG_MIN'(0)}) & ~om) == '0;
    match_o = ent_i.vld && tid_ok && page_ok;
    ra_o    = ({ent_i.rpn, PG_MIN'(0)} & ~RA_W'(om)) | RA_W'(ea_i & om);
  end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N  = 20,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  match_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic          multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IW'(i);
    end
    any_o   = |match_i;
    multi_o = (match_i & (match_i - N'(1))) != '0;
  end
endmodule

// File: rtl/tlb_vp_mmu.sv
module tlb_vp_mmu
  import tlb_vp_pkg::*;
#(
  parameter int N_ENT = 20,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic             wr_vld_i,
  input  logic [EPN_W-1:0] wr_epn_i,
  input  logic [RPN_W-1:0] wr_rpn_i,
  input  logic [SZ_W-1:0]  wr_sz_i,
  input  logic [TID_W-1:0] wr_tid_i,
  input  logic             lk_vld_i,
  input  logic [EA_W-1:0]  lk_ea_i,
  input  logic [TID_W-1:0] lk_pid_i,
  input  logic             mh_en_i,
  output logic             hit_o,
  output logic [RA_W-1:0]  ra_o,
  output logic [IW-1:0]    idx_o,
  output logic             multi_hit_o
);
  tlb_ent_t        ents [N_ENT];
  logic [N_ENT-1:0] match_v;
  logic [RA_W-1:0] ra_v [N_ENT];
  logic            any_m, multi_m;
  logic [IW-1:0]   sel_idx;
  logic [RA_W-1:0] sel_ra;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
    end else if (wr_en_i && (int'(wr_idx_i) < N_ENT)) begin
      ents[wr_idx_i] <= '{vld: wr_vld_i, epn: wr_epn_i, rpn: wr_rpn_i,
                          sz: wr_sz_i, tid: wr_tid_i};
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    tlb_entry_cmp u_cmp (
      .ent_i  (ents[g]),
      .ea_i   (lk_ea_i),
      .pid_i  (lk_pid_i),
      .match_o(match_v[g]),
      .ra_o   (ra_v[g])
    );
  end

  tlb_prio_sel #(.N(N_ENT)) u_sel (
    .match_i(match_v),
    .any_o  (any_m),
    .idx_o  (sel_idx),
    .multi_o(multi_m)
  );

  always_comb begin
    sel_ra = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (sel_idx == IW'(i)) sel_ra = ra_v[i];
    end
    hit_o       = lk_vld_i && any_m;
    ra_o        = hit_o ? sel_ra : '0;
    idx_o       = hit_o ? sel_idx : '0;
    multi_hit_o = lk_vld_i && mh_en_i && multi_m;
  end

  a_r6_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ra_o == '0 && idx_o == '0));
  a_r8_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> (hit_o && mh_en_i));
  a_r8_two_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> ($countones(match_v) >= 2));
  a_r7_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_v[idx_o] && ((match_v & ((N_ENT'(1) << idx_o) - N_ENT'(1))) == '0)));
endmodule

// File: tb/tlb_vp_mmu_test.sv
module tlb_vp_mmu_test;
  localparam int PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        wr_en_i = 0, wr_vld_i = 0, lk_vld_i = 0, mh_en_i = 0;
  logic [4:0]  wr_idx_i = 0, wr_sz_i = 0;
  logic [19:0] wr_epn_i = 0;
  logic [23:0] wr_rpn_i = 0;
  logic [7:0]  wr_tid_i = 0, lk_pid_i = 0;
  logic [31:0] lk_ea_i = 0;
  logic        hit_o, multi_hit_o;
  logic [35:0] ra_o;
  logic [4:0]  idx_o;
  int checks = 0, errors = 0;

  tlb_vp_mmu uut (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  typedef struct packed {
    logic [31:0] ea; logic [7:0] pid; logic mh;
    logic hit; logic [4:0] idx; logic [35:0] ra; logic mhx;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{32'hFFFFF123, 8'd3, 1'b0, 1'b1, 5'd0, 36'h07FFFF123, 1'b0}, // R3 R4 R5 global 4K
    '{32'hFE123456, 8'd5, 1'b0, 1'b1, 5'd1, 36'hFFE123456, 1'b0}, // R5 tid match 16M
    '{32'hFE123456, 8'd6, 1'b0, 1'b0, 5'd0, 36'h0,         1'b0}, // R5 tid mismatch
    '{32'h9ABCDEF0, 8'd1, 1'b0, 1'b1, 5'd2, 36'hC1ABCDEF0, 1'b0}, // R4 512M
    '{32'hA0000004, 8'd1, 1'b0, 1'b1, 5'd3, 36'hC20000004, 1'b0}, // R3 256M
    '{32'hF803FFFF, 8'd7, 1'b0, 1'b1, 5'd5, 36'hFF803FFFF, 1'b0}, // R3 top of 256K
    '{32'hF8040000, 8'd7, 1'b0, 1'b0, 5'd0, 36'h0,         1'b0}, // R3 R6 past 256K
    '{32'hC0000010, 8'd0, 1'b1, 1'b0, 5'd0, 36'h0,         1'b0}, // R10 invalid entry
    '{32'h12345678, 8'd2, 1'b1, 1'b1, 5'd4, 36'h012345678, 1'b1}, // R7 R8 multi on
    '{32'h12345678, 8'd2, 1'b0, 1'b1, 5'd4, 36'h012345678, 1'b0}, // R8 multi off
    '{32'h7FFFFFFF, 8'd9, 1'b1, 1'b1, 5'd4, 36'h07FFFFFFF, 1'b1}  // R7 2G edge
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic vld, input logic [31:0] ea,
                    input logic [35:0] ra, input int sz, input int tid);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 5'(idx); wr_vld_i = vld; wr_epn_i = ea[31:12];
    wr_rpn_i = ra[35:12]; wr_sz_i = 5'(sz); wr_tid_i = 8'(tid);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic look(input logic [31:0] ea, input int pid, input logic mh);
    @(negedge clk_i);
    lk_vld_i = 1; lk_ea_i = ea; lk_pid_i = 8'(pid); mh_en_i = mh;
    #1;
  endtask

  task automatic expect_res(input string tag, input logic h, input logic [4:0] i,
                            input logic [35:0] r, input logic m);
    chk({tag, " hit"}, 64'(hit_o), 64'(h));
    chk({tag, " idx"}, 64'(idx_o), 64'(i));
    chk({tag, " ra"},  64'(ra_o), 64'(r));
    chk({tag, " mh"},  64'(multi_hit_o), 64'(m));
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    look(32'h0000_0000, 0, 1);
    expect_res("R1 reset", 0, 0, 0, 0);
    look(32'hFFFF_F000, 0, 1);
    expect_res("R1 reset high", 0, 0, 0, 0);
    lk_vld_i = 0;

    wr(0, 1, 32'hFFFFF000, 36'h07FFFF000, 0, 0);
    wr(1, 1, 32'hFE000000, 36'hFFE000000, 12, 5);
    wr(2, 1, 32'h80000000, 36'hC00000000, 17, 0);
    wr(3, 1, 32'hA0000000, 36'hC20000000, 16, 0);
    wr(4, 1, 32'h00000000, 36'h000000000, 19, 0);
    wr(5, 1, 32'hF8000000, 36'hFF8000000, 6, 7);
    wr(6, 0, 32'hC0000000, 36'hC40000000, 16, 0);
    wr(8, 1, 32'h00000000, 36'h100000000, 19, 0);

    for (int v = 0; v < 11; v++) begin
      look(VEC[v].ea, int'(VEC[v].pid), VEC[v].mh);
      expect_res($sformatf("vec%0d R3-family", v), VEC[v].hit, VEC[v].idx, VEC[v].ra, VEC[v].mhx);
    end

    look(32'h12345678, 2, 1);
    lk_vld_i = 0; #1;
    expect_res("R6 lookup idle", 0, 0, 0, 0);

    // R2: same-cycle lookup sees old, next cycle sees new
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 10; wr_vld_i = 1; wr_epn_i = 20'hF0000;
    wr_rpn_i = 24'hF00000; wr_sz_i = 13; wr_tid_i = 0;
    lk_vld_i = 1; lk_ea_i = 32'hF0001000; lk_pid_i = 3; mh_en_i = 1;
    #1;
    expect_res("R2 old contents", 0, 0, 0, 0);
    @(negedge clk_i);
    wr_en_i = 0; #1;
    expect_res("R2 new contents", 1, 10, 36'hF00001000, 0);

    // R9: out-of-range index ignored
    wr(25, 1, 32'hE0000000, 36'hFE0000000, 16, 0);
    look(32'hE0000000, 0, 1);
    expect_res("R9 ignored write", 0, 0, 0, 0);

    // R10: invalidate entry 8, multi-hit disappears
    wr(8, 0, 32'h00000000, 36'h100000000, 19, 0);
    look(32'h12345678, 2, 1);
    expect_res("R10 invalidated", 1, 4, 36'h012345678, 0);

    // R7: invalidate 4, entry 8 alone would not match, so miss
    wr(4, 0, 32'h00000000, 36'h0, 19, 0);
    look(32'h12345678, 2, 1);
    expect_res("R7 R6 all gone", 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule